// File: doc/BRIEF.md
# Banked Byte Rotate and Fill Execution Slice

This block is one execution slice of an 8-bit accumulator-style core. It accepts a 16-bit instruction word and carries out two byte operations on a banked data memory. The first rotates a byte one place right, with bit 0 wrapping into bit 7 and no carry involved. The second forces a byte to all ones. The rotate can return its result either to the working register (W) or to the memory byte it read, and it updates the negative (N) and zero (Z) flags. The fill operation always writes memory and leaves the flags alone.

The 12-bit data address is built from the instruction's 8-bit file field and a per-instruction bank-mode bit. In banked mode the upper four address bits come from a bank register. In access mode the low part of the file range maps into the bottom of memory and the upper part maps into the top page. When extended mode is on, access-mode operands below the split point are instead taken relative to a 12-bit index base register.

Execution follows a fixed four-phase loop: decode, read, process, write. One instruction can be issued per loop, and its effects appear when the loop returns to decode. A load port and a peek port let the surrounding logic fill and inspect the data memory.

Top module: `rotset_exec_unit`

## Requirements
- R1: After reset, W, N, Z, the bank register, the index base and the illegal flag are all 0, and the phase output is 0 (decode).
- R2: The phase output steps 0,1,2,3 (decode, read, process, write) and then repeats. An instruction is sampled on the clock edge that ends phase 0, and its results become visible once the phase output is back at 0.
- R3: An instruction whose bits [15:10] equal 010000 is a rotate, with bit 9 as the destination bit and bit 8 as the bank-mode bit. Its result is the source byte shifted one place right, with source bit 0 placed in result bit 7 (D7h gives EBh, 01h gives 80h).
- R4: When the rotate destination bit is 1, the result is written to the addressed byte and W is left unchanged. When it is 0, the result goes to W and the byte is left unchanged.
- R5: A rotate sets N to bit 7 of its result, and sets Z to 1 when the result is 00h and to 0 otherwise. A fill leaves N and Z unchanged.
- R6: An instruction whose bits [15:9] equal 0110100 is a fill, with bit 8 as the bank-mode bit. It writes FFh to the addressed byte and leaves W unchanged.
- R7: When the bank-mode bit is 1, the address is {bank[3:0], file}, and ext_mode has no effect on it.
- R8: When the bank-mode bit is 0 and no index override applies, file values 00h..5Fh address 000h..05Fh and file values 60h..FFh address F60h..FFFh.
- R9: When the bank-mode bit is 0, ext_mode is 1 and the file field is at most 5Fh, the address is (index base + file) modulo 4096.
- R10: An issued word matching neither encoding changes no register, memory byte or flag. illegal_out is 1 for exactly the one cycle in which phase is 1.
- R11: When instr_valid is 0 at the end of phase 0, that loop changes nothing and illegal_out stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present at the end of phase 0 |
| instr | input | 16 | Instruction word |
| ext_mode | input | 1 | Enables indexed addressing for low access-mode operands |
| bank_we | input | 1 | Load the bank register |
| bank_wdata | input | 4 | New bank value |
| index_we | input | 1 | Load the index base register |
| index_wdata | input | 12 | New index base value |
| ld_we | input | 1 | Write a byte through the load port |
| ld_addr | input | 12 | Load port address |
| ld_data | input | 8 | Load port data |
| peek_addr | input | 12 | Inspection address |
| peek_data | output | 8 | Memory byte at peek_addr |
| w_out | output | 8 | Working register |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |
| phase_out | output | 2 | Current phase (0 decode, 1 read, 2 process, 3 write) |
| illegal_out | output | 1 | Pulse for an unrecognised instruction |

## Verification
A latched address that is wrong shows up at the peek port one loop after issue: the expected byte stays unchanged and some other byte takes the result. A corrupted destination bit or operation code shows up at the same point, as W or the N/Z outputs moving when they should not, or failing to move when they should. The phase counter and the decode latch are observed every cycle through phase_out and illegal_out, so a skipped phase or a stuck pulse is reported within one clock.

// File: rtl/rotset_pkg.sv
package rotset_pkg;

    typedef enum logic [1:0] {
        PH_DECODE = 2'd0,
        PH_READ   = 2'd1,
        PH_EXEC   = 2'd2,
        PH_WRITE  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        OP_NOP  = 2'd0,
        OP_ROR  = 2'd1,
        OP_FILL = 2'd2,
        OP_BAD  = 2'd3
    } op_e;

    localparam int          INSTR_W  = 16;
    localparam int          FILE_W   = 8;
    localparam logic [5:0]  ROR_PFX  = 6'b010000;
    localparam logic [6:0]  FILL_PFX = 7'b0110100;

    typedef struct packed {
        op_e                op;
        logic               to_file;
        logic               banked;
        logic [FILE_W-1:0]  fsel;
    } dec_t;

    function automatic dec_t decode_word(input logic valid, input logic [INSTR_W-1:0] iw);
        dec_t d;
        d.fsel    = iw[FILE_W-1:0];
        d.banked  = iw[8];
        d.to_file = 1'b0;
        if (!valid) begin
            d.op = OP_NOP;
        end else if (iw[15:10] == ROR_PFX) begin
            d.op      = OP_ROR;
            d.to_file = iw[9];
        end else if (iw[15:9] == FILL_PFX) begin
            d.op      = OP_FILL;
            d.to_file = 1'b1;
        end else begin
            d.op = OP_BAD;
        end
        return d;
    endfunction

endpackage

// File: rtl/rotset_addr_gen.sv
module rotset_addr_gen #(
    parameter int FW           = 8,
    parameter int AW           = 12,
    parameter int ACCESS_SPLIT = 96
) (
    input  logic [FW-1:0]    fsel,
    input  logic             banked,
    input  logic             ext_mode,
    input  logic [AW-FW-1:0] bank,
    input  logic [AW-1:0]    index_base,
    output logic [AW-1:0]    eaddr
);
    localparam int          BW    = AW - FW;
    localparam logic [FW-1:0] SPLIT = FW'(ACCESS_SPLIT);

    logic low_half;
    assign low_half = (fsel < SPLIT);

    always_comb begin
        if (banked) begin
            eaddr = {bank, fsel};
        end else if (ext_mode && low_half) begin
            eaddr = index_base + {{BW{1'b0}}, fsel};
        end else if (low_half) begin
            eaddr = {{BW{1'b0}}, fsel};
        end else begin
            eaddr = {{BW{1'b1}}, fsel};
        end
    end
endmodule

// File: rtl/rotset_alu.sv
module rotset_alu
    import rotset_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e           op,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          neg,
    output logic          zero
);
    always_comb begin
        unique case (op)
            OP_ROR:  dout = {din[0], din[DW-1:1]};
            OP_FILL: dout = '1;
            default: dout = din;
        endcase
    end

    assign neg  = dout[DW-1];
    assign zero = (dout == '0);
endmodule

// File: rtl/rotset_regfile.sv
module rotset_regfile #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/rotset_exec_unit.sv
module rotset_exec_unit
    import rotset_pkg::*;
#(
    parameter int AW           = 12,
    parameter int DW           = 8,
    parameter int ACCESS_SPLIT = 96
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 instr_valid,
    input  logic [INSTR_W-1:0]   instr,
    input  logic                 ext_mode,
    input  logic                 bank_we,
    input  logic [AW-FILE_W-1:0] bank_wdata,
    input  logic                 index_we,
    input  logic [AW-1:0]        index_wdata,
    input  logic                 ld_we,
    input  logic [AW-1:0]        ld_addr,
    input  logic [DW-1:0]        ld_data,
    input  logic [AW-1:0]        peek_addr,
    output logic [DW-1:0]        peek_data,
    output logic [DW-1:0]        w_out,
    output logic                 n_out,
    output logic                 z_out,
    output logic [1:0]           phase_out,
    output logic                 illegal_out
);
    localparam int BW = AW - FILE_W;

    phase_e         phase_q;
    dec_t           dec_now, dec_q;
    logic [AW-1:0]  ea_now, ea_q;
    logic [BW-1:0]  bank_q;
    logic [AW-1:0]  index_q;
    logic [DW-1:0]  rd_now, opnd_q, alu_res, res_q, w_q;
    logic           alu_n, alu_z, n_q, z_q, res_n_q, res_z_q, illegal_q;
    logic           exec_we, mem_we;
    logic [AW-1:0]  mem_waddr;
    logic [DW-1:0]  mem_wdata;

    assign dec_now = decode_word(instr_valid, instr);

    rotset_addr_gen #(.FW(FILE_W), .AW(AW), .ACCESS_SPLIT(ACCESS_SPLIT)) u_addr (
        .fsel(dec_now.fsel), .banked(dec_now.banked), .ext_mode(ext_mode),
        .bank(bank_q), .index_base(index_q), .eaddr(ea_now)
    );

    rotset_alu #(.DW(DW)) u_alu (
        .op(dec_q.op), .din(opnd_q), .dout(alu_res), .neg(alu_n), .zero(alu_z)
    );

    assign exec_we   = (phase_q == PH_WRITE) &&
                       ((dec_q.op == OP_FILL) || (dec_q.op == OP_ROR && dec_q.to_file));
    assign mem_we    = exec_we || ld_we;
    assign mem_waddr = exec_we ? ea_q  : ld_addr;
    assign mem_wdata = exec_we ? res_q : ld_data;

    rotset_regfile #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr_a(ea_q), .rdata_a(rd_now),
        .raddr_b(peek_addr), .rdata_b(peek_data)
    );

    // Phase sequencer and decode latch
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_DECODE;
            dec_q     <= '0;
            ea_q      <= '0;
            illegal_q <= 1'b0;
        end else begin
            phase_q   <= phase_e'(phase_q + 2'd1);
            illegal_q <= 1'b0;
            if (phase_q == PH_DECODE) begin
                dec_q     <= dec_now;
                ea_q      <= ea_now;
                illegal_q <= (dec_now.op == OP_BAD);
            end
        end
    end

    // Read and process stages
    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q  <= '0;
            res_q   <= '0;
            res_n_q <= 1'b0;
            res_z_q <= 1'b0;
        end else begin
            if (phase_q == PH_READ) begin
                opnd_q <= rd_now;
            end
            if (phase_q == PH_EXEC) begin
                res_q   <= alu_res;
                res_n_q <= alu_n;
                res_z_q <= alu_z;
            end
        end
    end

    // Architectural registers
    always_ff @(posedge clk) begin
        if (rst) begin
            w_q     <= '0;
            n_q     <= 1'b0;
            z_q     <= 1'b0;
            bank_q  <= '0;
            index_q <= '0;
        end else begin
            if (bank_we)  bank_q  <= bank_wdata;
            if (index_we) index_q <= index_wdata;
            if (phase_q == PH_WRITE && dec_q.op == OP_ROR) begin
                n_q <= res_n_q;
                z_q <= res_z_q;
                if (!dec_q.to_file) begin
                    w_q <= res_q;
                end
            end
        end
    end

    assign w_out       = w_q;
    assign n_out       = n_q;
    assign z_out       = z_q;
    assign phase_out   = phase_q;
    assign illegal_out = illegal_q;
endmodule

// File: rtl/rotset_exec_unit_checker.sv
module rotset_exec_unit_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] phase_out,
    input logic       illegal_out,
    input logic [7:0] w_out,
    input logic       n_out,
    input logic       z_out
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
        armed |-> (phase_out == $past(phase_out) + 2'd1));

    p_hold_between_r2: assert property (@(posedge clk) disable iff (rst)
        (armed && phase_out != 2'd0) |-> ($stable(w_out) && $stable(n_out) && $stable(z_out)));

    p_illegal_phase_r10: assert property (@(posedge clk) disable iff (rst)
        illegal_out |-> (phase_out == 2'd1));

    p_illegal_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        illegal_out |=> !illegal_out);

    p_zero_not_neg_r5: assert property (@(posedge clk) disable iff (rst)
        z_out |-> !n_out);
endmodule

bind rotset_exec_unit rotset_exec_unit_checker u_chk (
    .clk(clk), .rst(rst), .phase_out(phase_out), .illegal_out(illegal_out),
    .w_out(w_out), .n_out(n_out), .z_out(z_out)
);

// File: tb/rotset_exec_unit_test.sv
module rotset_exec_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic        ext_mode = 1'b0;
    logic        bank_we = 1'b0;
    logic [3:0]  bank_wdata = '0;
    logic        index_we = 1'b0;
    logic [11:0] index_wdata = '0;
    logic        ld_we = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic [11:0] peek_addr = '0;
    logic [7:0]  peek_data, w_out;
    logic        n_out, z_out, illegal_out;
    logic [1:0]  phase_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    rotset_exec_unit uut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .ext_mode(ext_mode), .bank_we(bank_we), .bank_wdata(bank_wdata),
        .index_we(index_we), .index_wdata(index_wdata), .ld_we(ld_we),
        .ld_addr(ld_addr), .ld_data(ld_data), .peek_addr(peek_addr),
        .peek_data(peek_data), .w_out(w_out), .n_out(n_out), .z_out(z_out),
        .phase_out(phase_out), .illegal_out(illegal_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_mem [int];
    int mph = 0, mw = 0, mn = 0, mz = 0, mill = 0, mbank = 0, midx = 0;
    int pk = 0, pd = 0, pa = 0;

    function automatic int ea(input int f, input int a);
        if (a != 0)                return mbank * 256 + f;
        if (ext_mode && f <= 95)   return (midx + f) % 4096;
        if (f < 96)                return f;
        return 'hF00 + f;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mph = 0; mw = 0; mn = 0; mz = 0; mill = 0; mbank = 0; midx = 0; pk = 0;
        end else begin
            if (ld_we) m_mem[ld_addr] = ld_data;
            mill = 0;
            if (mph == 0) begin
                pk = 0;
                if (instr_valid) begin
                    if (instr[15:10] == 6'b010000) begin
                        pk = 1; pd = instr[9]; pa = ea(instr[7:0], instr[8]);
                    end else if (instr[15:9] == 7'b0110100) begin
                        pk = 2; pa = ea(instr[7:0], instr[8]);
                    end else begin
                        mill = 1;
                    end
                end
            end
            if (mph == 3) begin
                if (pk == 1) begin
                    int s, r;
                    s = m_mem.exists(pa) ? m_mem[pa] : 0;
                    r = ((s >> 1) | ((s & 1) << 7)) & 255;
                    mn = (r >> 7) & 1;
                    mz = (r == 0);
                    if (pd != 0) m_mem[pa] = r;
                    else         mw = r;
                end else if (pk == 2) begin
                    m_mem[pa] = 255;
                end
            end
            if (bank_we)  mbank = bank_wdata;
            if (index_we) midx  = index_wdata;
            mph = (mph + 1) % 4;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk("R2 phase", phase_out, mph);
            chk("R10 illegal flag", illegal_out, mill);
            chk("R4 W", w_out, mw);
            chk("R5 N", n_out, mn);
            chk("R5 Z", z_out, mz);
            if (m_mem.exists(peek_addr)) chk("R3 memory", peek_data, m_mem[peek_addr]);
        end
        if (cycles > 20000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic load(input int a, input int d);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = 12'(a); ld_data = 8'(d);
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic set_bank(input int b);
        @(negedge clk); bank_we = 1'b1; bank_wdata = 4'(b);
        @(negedge clk); bank_we = 1'b0;
    endtask

    task automatic set_index(input int x);
        @(negedge clk); index_we = 1'b1; index_wdata = 12'(x);
        @(negedge clk); index_we = 1'b0;
    endtask

    // Issue in phase 0, return when phase is back at 0 with results visible
    task automatic issue(input logic v, input logic [15:0] iw, input int peek);
        peek_addr = 12'(peek);
        @(negedge clk);
        while (phase_out != 2'd0) @(negedge clk);
        instr_valid = v; instr = iw;
        @(negedge clk);
        instr_valid = 1'b0; instr = '0;
        repeat (3) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 W", w_out, 0);
        chk("R1 N", n_out, 0);
        chk("R1 Z", z_out, 0);
        chk("R1 phase", phase_out, 0);
        chk("R1 illegal", illegal_out, 0);

        // R3/R4: rotate back to file, access low address 10h
        load('h010, 'hD7);
        issue(1'b1, 16'h4210, 'h010);
        chk("R3 rotate D7 to file", peek_data, 'hEB);
        chk("R4 W unchanged on d=1", w_out, 0);
        chk("R5 N from result", n_out, 1);
        chk("R5 Z clear", z_out, 0);

        // R4: rotate to W, file unchanged
        issue(1'b1, 16'h4010, 'h010);
        chk("R4 W gets result", w_out, 'hF5);
        chk("R4 file unchanged on d=0", peek_data, 'hEB);

        // R3: 01h -> 80h
        load('h020, 'h01);
        issue(1'b1, 16'h4020, 'h020);
        chk("R3 01 to 80", w_out, 'h80);

        // R5: zero result
        load('h030, 'h00);
        issue(1'b1, 16'h4230, 'h030);
        chk("R5 Z set", z_out, 1);
        chk("R5 N clear", n_out, 0);

        // R7: banked address
        set_bank(5);
        load('h522, 'h02);
        issue(1'b1, 16'h4322, 'h522);
        chk("R7 banked address", peek_data, 'h01);

        // R8: access high half maps to top page
        load('hF80, 'h04);
        issue(1'b1, 16'h4280, 'hF80);
        chk("R8 access top page", peek_data, 'h02);

        // R9: indexed override
        set_index('h300);
        ext_mode = 1'b1;
        load('h320, 'h08);
        issue(1'b1, 16'h4220, 'h320);
        chk("R9 indexed address", peek_data, 'h04);
        load('hF60, 'h10);
        issue(1'b1, 16'h4260, 'hF60);
        chk("R8 no override at 60h", peek_data, 'h08);
        load('h540, 'h20);
        issue(1'b1, 16'h4340, 'h540);
        chk("R7 banked ignores ext_mode", peek_data, 'h10);
        set_index('hFF0);
        load('h010, 'h40);
        issue(1'b1, 16'h4220, 'h010);
        chk("R9 index wraps", peek_data, 'h20);
        ext_mode = 1'b0;

        // R6/R5: fill keeps flags and W
        load('h020, 'h80);
        issue(1'b1, 16'h4020, 'h020);
        chk("R5 N before fill", n_out, 0);
        load('h005, 'h12);
        issue(1'b1, 16'h6805, 'h005);
        chk("R6 fill writes FF", peek_data, 'hFF);
        chk("R5 fill keeps N", n_out, 0);
        chk("R6 fill keeps W", w_out, 'h40);
        load('h577, 'h00);
        issue(1'b1, 16'h6977, 'h577);
        chk("R6 banked fill", peek_data, 'hFF);

        // R10: illegal word
        load('h033, 'h55);
        issue(1'b1, 16'hFF33, 'h033);
        chk("R10 memory unchanged", peek_data, 'h55);
        chk("R10 W unchanged", w_out, 'h40);
        issue(1'b1, 16'h4433, 'h033);
        chk("R10 near-miss unchanged", peek_data, 'h55);

        // R11: invalid issue slot
        issue(1'b0, 16'h4233, 'h033);
        chk("R11 no effect", peek_data, 'h55);
        chk("R11 W unchanged", w_out, 'h40);

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule